// File: doc/BRIEF.md
# Two-Lag Recursive Filter with Split Loop Registers

This block is a first-section recursive filter that produces one output per accepted input sample. It follows y(n) = a·y(n−2) + x(n). The input is a 16-bit signed sample. The coefficient `a` is a 16-bit signed fraction with 15 fractional bits, so its range is −1.0 to just under +1.0. The running state is 24 bits wide.

The recursion holds two delays in its loop, and these are placed on either side of the multiplier rather than stacked together:

- One register holds the newest output y(n−1), which feeds the multiplier.
- A second register holds the rounded product, which feeds the adder.

As a result, the multiply and the add each fill a clock cycle of their own. The clock period is set by the slower of the two operators rather than by their sum. While the adder combines the current sample with a product, the multiplier is already working on the previous output. The relation between input and output is exactly that of the unsplit recursion.

Samples enter and leave through valid/ready streams.

- An input is accepted on a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. A stalled consumer therefore stops intake at once, and no sample is lost or repeated.
- Both loop registers advance only on an accepted sample, so gaps in the input stream do not disturb the recursion.
- The coefficient is a plain input that is held constant while the filter runs.

Top module: `lag2_iir_retimed`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Both loop registers are cleared, so the first two outputs equal the first two inputs, whatever the coefficient.
- R2: The k-th output is y(k) = sat(x(k) + q(a·y(k−2))), where y(−1) = y(−2) = 0. Cycles without an accepted input leave the state and `out_data` unchanged.
- R3: The adder saturates. A sum above 8388607 gives 8388607, and a sum below −8388608 gives −8388608.
- R4: The product of the 24-bit state and the coefficient is rounded to nearest by adding 2^14 and then shifting right arithmetically by 15. Exact halves therefore round upward: 0.5 gives 1 and −0.5 gives 0.
- R5: The rounded product is cut to its low 24 bits before the add, with no saturation. For a = −1.0 and y(n−2) = −8388608, the term added is −8388608.
- R6: `in_ready` equals (!`out_valid` || `out_ready`). If `out_valid` is high and `out_ready` is high while no input is accepted, `out_valid` is 0 in the next cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: A sample accepted on one clock edge appears on `out_data` with `out_valid` high right after that edge. With `out_ready` held high, one sample is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef | input | 16 | Feedback coefficient, signed, 15 fractional bits |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | 24 | Signed output sample y(n) |

## Verification
Two things can fall in the same cycle: the adder uses the product register to finish y(n), and the multiplier overwrites that same register with the product for y(n+1). A fault in the ordering would pair a sample with the wrong lag. Back-to-back streams with `out_ready` held high force both updates into every cycle. Each output is compared against a model written as a plain two-lag history, which knows nothing of the split loop. A second overlap, output drain and new intake in one cycle, is provoked by releasing a stall while a sample waits. It is judged by the value that follows the stall and by the value that follows an idle gap.

// File: rtl/lag2_iir_pkg.sv
package lag2_iir_pkg;
  localparam int unsigned DEF_IN_W   = 16;
  localparam int unsigned DEF_COEF_W = 16;
  localparam int unsigned DEF_FRAC   = 15;
  localparam int unsigned DEF_ACC_W  = 24;
endpackage

// File: rtl/lag2_iir_flow.sv
module lag2_iir_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic take
);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      out_valid <= 1'b0;
    else if (take)   out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end
endmodule

// File: rtl/lag2_iir_mul_stage.sv
module lag2_iir_mul_stage #(
  parameter int unsigned ACC_W  = lag2_iir_pkg::DEF_ACC_W,
  parameter int unsigned COEF_W = lag2_iir_pkg::DEF_COEF_W,
  parameter int unsigned FRAC   = lag2_iir_pkg::DEF_FRAC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [ACC_W-1:0]  y_last,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  prod_q
);
  localparam int unsigned PROD_W = ACC_W + COEF_W;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC - 1);

  logic signed [PROD_W-1:0] prod_full;
  logic signed [PROD_W-1:0] prod_rnd;
  logic signed [ACC_W-1:0]  prod_cut;

  always_comb begin
    prod_full = PROD_W'(y_last) * PROD_W'(coef);
    prod_rnd  = prod_full + HALF;
    prod_cut  = ACC_W'(prod_rnd >>> FRAC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= prod_cut;
  end
endmodule

// File: rtl/lag2_iir_add_stage.sv
module lag2_iir_add_stage #(
  parameter int unsigned IN_W  = lag2_iir_pkg::DEF_IN_W,
  parameter int unsigned ACC_W = lag2_iir_pkg::DEF_ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  x_in,
  input  logic signed [ACC_W-1:0] prod_q,
  output logic signed [ACC_W-1:0] y_q
);
  localparam int unsigned SUM_W = ACC_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum;
  logic signed [ACC_W-1:0] y_next;

  always_comb begin
    sum = SUM_W'(x_in) + SUM_W'(prod_q);
    if (sum[SUM_W-1] != sum[SUM_W-2])
      y_next = sum[SUM_W-1] ? NEG_LIM : POS_LIM;
    else
      y_next = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= y_next;
  end
endmodule

// File: rtl/lag2_iir_retimed.sv
module lag2_iir_retimed #(
  parameter int unsigned IN_W   = lag2_iir_pkg::DEF_IN_W,
  parameter int unsigned COEF_W = lag2_iir_pkg::DEF_COEF_W,
  parameter int unsigned FRAC   = lag2_iir_pkg::DEF_FRAC,
  parameter int unsigned ACC_W  = lag2_iir_pkg::DEF_ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coef,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data
);
  logic take;
  logic signed [ACC_W-1:0] y_reg;
  logic signed [ACC_W-1:0] p_reg;

  lag2_iir_flow flow_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .take(take)
  );

  // Loop delay 1: y(n-1) held ahead of the multiplier.
  lag2_iir_add_stage #(.IN_W(IN_W), .ACC_W(ACC_W)) add_i (
    .clk(clk), .rst_n(rst_n), .en(take), .x_in($signed(in_data)),
    .prod_q(p_reg), .y_q(y_reg)
  );

  // Loop delay 2: rounded product held ahead of the adder.
  lag2_iir_mul_stage #(.ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC(FRAC)) mul_i (
    .clk(clk), .rst_n(rst_n), .en(take), .y_last(y_reg),
    .coef($signed(coef)), .prod_q(p_reg)
  );

  assign out_data = y_reg;
endmodule

// File: rtl/lag2_iir_chk.sv
module lag2_iir_chk #(
  parameter int unsigned ACC_W = lag2_iir_pkg::DEF_ACC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data
);
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_stall_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_drain_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
  p_drop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
  p_accept_show_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_idle_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));
endmodule

bind lag2_iir_retimed lag2_iir_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/lag2_iir_retimed_tb_top.sv
module lag2_iir_retimed_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] coef = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int wraps = 0;
  longint ym1 = 0, ym2 = 0;

  lag2_iir_retimed dut_i (
    .clk(clk), .rst_n(rst_n), .coef(coef), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, MAX_CYCLES);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint dout();
    return longint'($signed(out_data));
  endfunction

  // Reference: plain two-lag history.
  function automatic longint model(input longint x);
    longint p, r, t, s;
    p = ym2 * longint'($signed(coef));
    r = (p + 16384) >>> 15;
    t = r & 64'hFF_FFFF;
    if (t >= 64'sd8388608) t = t - 64'sd16777216;
    if (t != r) wraps++;
    s = x + t;
    if (s > 8388607) s = 8388607;
    if (s < -8388608) s = -8388608;
    ym2 = ym1;
    ym1 = s;
    return s;
  endfunction

  task automatic do_reset(input logic [15:0] a);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; coef = a;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ym1 = 0; ym2 = 0;
  endtask

  // Called at a negedge: offer x, let it be taken, check at next negedge.
  task automatic step(input longint x, input string req, output longint y);
    longint e;
    in_valid = 1'b1; in_data = 16'(x);
    e = model(x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, longint'(out_valid), 1);
    check(req, dout(), e);
    y = dout();
  endtask

  task automatic t_reset();
    do_reset(16'h4000);
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 in_ready", longint'(in_ready), 1);
  endtask

  task automatic t_first_two();
    longint y;
    do_reset(16'h4000);
    step(100, "R1 first", y);   check("R1 first eq x", y, 100);
    step(-200, "R1 second", y); check("R1 second eq x", y, -200);
    step(300, "R2 third", y);   check("R2 third", y, 350);
    step(0, "R2 fourth", y);    check("R2 fourth", y, -100);
  endtask

  task automatic t_stream();
    longint y;
    do_reset(16'hD000);
    for (int k = 0; k < 24; k++) begin
      longint x;
      x = ((k * 7919) % 65536) - 32768;
      step(x, "R8 R2 stream", y);
    end
  endtask

  task automatic t_sat();
    longint y;
    do_reset(16'h7FFF);
    for (int k = 0; k < 700; k++) step(32767, "R3 pos", y);
    check("R3 pos limit", y, 8388607);
    do_reset(16'h7FFF);
    for (int k = 0; k < 700; k++) step(-32768, "R3 neg", y);
    check("R3 neg limit", y, -8388608);
  endtask

  task automatic t_round();
    longint y;
    do_reset(16'h0001);
    step(16384, "R4 a", y); step(0, "R4 a", y); step(0, "R4 a", y);
    check("R4 half up", y, 1);
    do_reset(16'h0001);
    step(16383, "R4 b", y); step(0, "R4 b", y); step(0, "R4 b", y);
    check("R4 below half", y, 0);
    do_reset(16'h0001);
    step(-16384, "R4 c", y); step(0, "R4 c", y); step(0, "R4 c", y);
    check("R4 neg half", y, 0);
    do_reset(16'h0001);
    step(-16385, "R4 d", y); step(0, "R4 d", y); step(0, "R4 d", y);
    check("R4 neg beyond", y, -1);
  endtask

  task automatic t_trunc();
    longint y;
    do_reset(16'h8000);
    wraps = 0;
    for (int k = 0; k < 800; k++) begin
      longint x;
      x = (((k / 2) % 2) == 0) ? -32768 : 32767;
      step(x, "R5 wrap", y);
    end
    check("R5 wrap seen", longint'(wraps > 0), 1);
  endtask

  task automatic t_backpressure();
    longint y, e;
    do_reset(16'h2000);
    step(1000, "R8 bp", y);
    step(-500, "R8 bp", y);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 16'(700);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 stall ready", longint'(in_ready), 0);
      check("R7 stall valid", longint'(out_valid), 1);
      check("R7 stall data", dout(), y);
    end
    out_ready = 1'b1;
    e = model(700);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_data = 16'h7FFF;
    check("R6 release", dout(), e);
    @(posedge clk);
    @(negedge clk);
    check("R6 drain", longint'(out_valid), 0);
    repeat (2) @(negedge clk);
    check("R2 gap hold", dout(), e);
    step(-40, "R2 after gap", y);
  endtask

  initial begin
    t_reset();
    t_first_two();
    t_stream();
    t_round();
    t_sat();
    t_trunc();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule